// File: doc/BRIEF.md
# Stall-Hiding Group Interleave Scheduler

This block decides, on every clock, which resident group of work items a single SIMD core issues from. A group is a set of eight work items running one shared instruction stream with its own execution context. Several groups sit on the core at once. When the issuing group starts a long-latency operation such as a texture fetch, the core sends a stall pulse carrying that group's number. The scheduler then stops picking that group and issues another runnable one, so the ALUs never wait on the memory system. A wake pulse with the same number comes back when the data arrives, and the group becomes runnable again.

Each group is always in one of three states. It is runnable, it is stalled waiting for data, or it is done. A per-group done level takes a group out of selection. The number of resident groups is the size of the context pool divided by the size of one context. Small contexts give many groups and more latency hiding. Large contexts give few groups. One or two issue slots can be built. In the dual-issue build, two different groups are chosen in the same clock. The choice among runnable groups rotates, starting just after the group that was issued last.

Top module: `gis_sched`

## Requirements
- R1: While reset is high and on the first clock after it, every issue_valid bit is 0. The first selection after reset starts from group 0.
- R2: A stall pulse with group number g, sampled at edge t, keeps g out of every issue slot on the outputs registered at edge t and later, until a wake for g is sampled.
- R3: A wake pulse for a stalled group g, sampled at edge t, makes g eligible on the outputs registered at edge t.
- R4: A group whose group_done bit is 1 at edge t is not issued on the outputs registered at that edge. Any pending stall of that group is cleared, so it is runnable once done falls.
- R5: Selection rotates. Candidates are examined in ascending group order, wrapping around, starting one past the group issued last in the highest valid slot. If no group has been issued since reset, the last group counts as issued last.
- R6: When no group is runnable, every issue_valid bit is 0 for that cycle, and the rotation point is kept.
- R7: With two issue slots, slot 1 holds the next runnable group after slot 0 in rotation order. The two slots never carry the same group. Slot 1 is valid only if slot 0 is valid.
- R8: When a stall and a wake for the same group are sampled at the same edge, the stall wins and the group ends up stalled.
- R9: The group count is POOL_WORDS / CTX_WORDS. issue_gid[s] (bits s*GID_W upward) is always below that count when issue_valid[s] is 1, and group numbers at or above it are ignored.
- R10: A stall on a group whose done bit is set has no effect. A wake on a group that is not stalled has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_req | input | 1 | Pulse: the group in stall_gid begins a long-latency wait |
| stall_gid | input | GID_W | Group that stalls |
| wake_req | input | 1 | Pulse: data for the group in wake_gid has arrived |
| wake_gid | input | GID_W | Group that wakes |
| group_done | input | NUM_GROUPS | Level, one bit per group: the group is finished |
| issue_valid | output | ISSUE_W | Registered: slot s carries a group |
| issue_gid | output | ISSUE_W*GID_W | Registered: group number per slot, slot 0 in the low bits |

## Verification
Every result is due exactly one clock after the stimulus that causes it. The output register captures the selection made from the state updated by the stall, wake and done values sampled at that same edge. The bench therefore drives each input set just after a falling edge and advances its reference model by one step. It compares all issue outputs at the next falling edge, so each compare sees the result of exactly one rising edge. Three builds run side by side from the same inputs: dual issue with four groups, single issue with four groups, and single issue with three groups. Random stall latencies are mixed with directed cases for same-edge stall and wake, done overrides, ignored events and the idle case.

// File: rtl/gis_pkg.sv
package gis_pkg;
  // Width of a group number; at least one bit even for a single group.
  function automatic int gid_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/gis_ctx_state.sv
// Per-group wait state. Produces the eligibility mask as it will be after
// the current edge, so the picker can act on this cycle's events.
module gis_ctx_state #(
  parameter int NG = 4,
  parameter int GW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stall_req,
  input  logic [GW-1:0] stall_gid,
  input  logic          wake_req,
  input  logic [GW-1:0] wake_gid,
  input  logic [NG-1:0] done_mask,
  output logic [NG-1:0] elig_nxt
);
  logic [NG-1:0] wait_q;
  logic [NG-1:0] wait_d;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    logic hit_stall;
    logic hit_wake;
    assign hit_stall = stall_req && (stall_gid == GW'(g));
    assign hit_wake  = wake_req  && (wake_gid  == GW'(g));

    always_comb begin
      if (done_mask[g])   wait_d[g] = 1'b0;   // finished clears any wait
      else if (hit_stall) wait_d[g] = 1'b1;   // stall beats same-edge wake
      else if (hit_wake)  wait_d[g] = 1'b0;
      else                wait_d[g] = wait_q[g];
    end

    always_ff @(posedge clk) begin
      if (rst) wait_q[g] <= 1'b0;
      else     wait_q[g] <= wait_d[g];
    end

    assign elig_nxt[g] = !done_mask[g] && !wait_d[g];
  end
endmodule

// File: rtl/gis_rr_pick.sv
// Finds the first set bit of mask_in strictly after start_gid, wrapping.
module gis_rr_pick #(
  parameter int NG = 4,
  parameter int GW = 2
) (
  input  logic [NG-1:0] mask_in,
  input  logic [GW-1:0] start_gid,
  output logic          hit,
  output logic [GW-1:0] pick_gid,
  output logic [NG-1:0] mask_out
);
  always_comb begin
    int idx;
    hit      = 1'b0;
    pick_gid = '0;
    for (int k = 1; k <= NG; k++) begin
      idx = int'(start_gid) + k;
      if (idx >= NG) idx = idx - NG;
      if (!hit && mask_in[idx]) begin
        hit      = 1'b1;
        pick_gid = GW'(idx);
      end
    end
    mask_out = mask_in;
    if (hit) mask_out[pick_gid] = 1'b0;
  end
endmodule

// File: rtl/gis_sched.sv
module gis_sched #(
  parameter int  POOL_WORDS = 128,
  parameter int  CTX_WORDS  = 32,
  parameter int  ISSUE_W    = 2,
  localparam int NUM_GROUPS = POOL_WORDS / CTX_WORDS,
  localparam int GID_W      = gis_pkg::gid_bits(NUM_GROUPS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     stall_req,
  input  logic [GID_W-1:0]         stall_gid,
  input  logic                     wake_req,
  input  logic [GID_W-1:0]         wake_gid,
  input  logic [NUM_GROUPS-1:0]    group_done,
  output logic [ISSUE_W-1:0]       issue_valid,
  output logic [ISSUE_W*GID_W-1:0] issue_gid
);
  logic [NUM_GROUPS-1:0] elig_nxt;
  logic [NUM_GROUPS-1:0] mask_c  [0:ISSUE_W];
  logic [GID_W-1:0]      start_c [0:ISSUE_W];
  logic [ISSUE_W-1:0]    hit_s;
  logic [GID_W-1:0]      pick_s  [0:ISSUE_W-1];
  logic [GID_W-1:0]      last_q;

  gis_ctx_state #(.NG(NUM_GROUPS), .GW(GID_W)) u_state (
    .clk       (clk),
    .rst       (rst),
    .stall_req (stall_req),
    .stall_gid (stall_gid),
    .wake_req  (wake_req),
    .wake_gid  (wake_gid),
    .done_mask (group_done),
    .elig_nxt  (elig_nxt)
  );

  assign mask_c[0]  = elig_nxt;
  assign start_c[0] = last_q;

  // Slot chain: each slot picks after the previous slot's choice.
  for (genvar s = 0; s < ISSUE_W; s++) begin : g_slot
    gis_rr_pick #(.NG(NUM_GROUPS), .GW(GID_W)) u_pick (
      .mask_in   (mask_c[s]),
      .start_gid (start_c[s]),
      .hit       (hit_s[s]),
      .pick_gid  (pick_s[s]),
      .mask_out  (mask_c[s+1])
    );
    assign start_c[s+1] = hit_s[s] ? pick_s[s] : start_c[s];

    always_ff @(posedge clk) begin
      if (rst) begin
        issue_valid[s]               <= 1'b0;
        issue_gid[s*GID_W +: GID_W]  <= '0;
      end else begin
        issue_valid[s]               <= hit_s[s];
        issue_gid[s*GID_W +: GID_W]  <= hit_s[s] ? pick_s[s] : '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) last_q <= GID_W'(NUM_GROUPS - 1);
    else     last_q <= start_c[ISSUE_W];
  end
endmodule

// File: rtl/gis_sched_chk.sv
module gis_sched_chk #(
  parameter int NG = 4,
  parameter int GW = 2,
  parameter int IW = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             stall_req,
  input logic [GW-1:0]    stall_gid,
  input logic [NG-1:0]    group_done,
  input logic [IW-1:0]    issue_valid,
  input logic [IW*GW-1:0] issue_gid
);
  logic          stall_q;
  logic [GW-1:0] stall_gid_q;
  logic [NG-1:0] done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stall_q     <= 1'b0;
      stall_gid_q <= '0;
      done_q      <= '0;
    end else begin
      stall_q     <= stall_req;
      stall_gid_q <= stall_gid;
      done_q      <= group_done;
    end
  end

  for (genvar s = 0; s < IW; s++) begin : g_slot
    logic [GW-1:0] gid_s;
    assign gid_s = issue_gid[s*GW +: GW];

    p_stall_excl_r2: assert property (@(posedge clk) disable iff (rst)
      (issue_valid[s] && stall_q) |-> (gid_s != stall_gid_q));

    p_done_excl_r4: assert property (@(posedge clk) disable iff (rst)
      issue_valid[s] |-> !done_q[gid_s]);

    p_gid_range_r9: assert property (@(posedge clk) disable iff (rst)
      issue_valid[s] |-> (int'(gid_s) < NG));
  end

  if (IW > 1) begin : g_dual
    p_distinct_r7: assert property (@(posedge clk) disable iff (rst)
      (issue_valid[0] && issue_valid[1]) |-> (issue_gid[GW-1:0] != issue_gid[2*GW-1:GW]));

    p_fill_order_r7: assert property (@(posedge clk) disable iff (rst)
      issue_valid[1] |-> issue_valid[0]);
  end
endmodule

bind gis_sched gis_sched_chk #(
  .NG (NUM_GROUPS),
  .GW (GID_W),
  .IW (ISSUE_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .stall_req   (stall_req),
  .stall_gid   (stall_gid),
  .group_done  (group_done),
  .issue_valid (issue_valid),
  .issue_gid   (issue_gid)
);

// File: tb/gis_sched_test.sv
module gis_sched_test;
  localparam int CLK_PERIOD = 10;
  localparam int NG = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       stall_req = 1'b0;
  logic [1:0] stall_gid = '0;
  logic       wake_req = 1'b0;
  logic [1:0] wake_gid = '0;
  logic [3:0] group_done = '0;

  logic [1:0] v2;
  logic [3:0] g2;
  logic [0:0] v1;
  logic [1:0] g1;
  logic [0:0] v3;
  logic [1:0] g3;

  always #(CLK_PERIOD/2) clk = ~clk;

  gis_sched #(.POOL_WORDS(128), .CTX_WORDS(32), .ISSUE_W(2)) uut (
    .clk(clk), .rst(rst), .stall_req(stall_req), .stall_gid(stall_gid),
    .wake_req(wake_req), .wake_gid(wake_gid), .group_done(group_done),
    .issue_valid(v2), .issue_gid(g2));

  gis_sched #(.POOL_WORDS(128), .CTX_WORDS(32), .ISSUE_W(1)) uut_one (
    .clk(clk), .rst(rst), .stall_req(stall_req), .stall_gid(stall_gid),
    .wake_req(wake_req), .wake_gid(wake_gid), .group_done(group_done),
    .issue_valid(v1), .issue_gid(g1));

  gis_sched #(.POOL_WORDS(96), .CTX_WORDS(32), .ISSUE_W(1)) uut_three (
    .clk(clk), .rst(rst), .stall_req(stall_req), .stall_gid(stall_gid),
    .wake_req(wake_req), .wake_gid(wake_gid), .group_done(group_done[2:0]),
    .issue_valid(v3), .issue_gid(g3));

  // Reference model state
  bit   stl [NG];
  int   lat [NG];
  int   ptr2, ptr1, ptr3;
  bit [1:0] ev2;
  bit [3:0] eg2;
  bit [1:0] ev1, ev3;
  bit [3:0] eg1, eg3;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic pick(input int n, input int w, input bit [3:0] dn, inout int p,
                      output bit [1:0] v, output bit [3:0] g);
    int cnt = 0;
    int last = p;
    v = '0;
    g = '0;
    for (int k = 1; k <= n; k++) begin
      int idx = (p + k) % n;
      if (cnt < w && !dn[idx] && !stl[idx]) begin
        v[cnt] = 1'b1;
        g[cnt*2 +: 2] = idx[1:0];
        cnt++;
        last = idx;
      end
    end
    p = last;
  endtask

  task automatic step(input bit sv, input int sg, input bit wv, input int wg,
                      input bit [3:0] dn, input string tag);
    stall_req  = sv;
    stall_gid  = sg[1:0];
    wake_req   = wv;
    wake_gid   = wg[1:0];
    group_done = dn;
    for (int g = 0; g < NG; g++) begin
      if (dn[g])                 stl[g] = 0;
      else if (sv && sg == g)    stl[g] = 1;
      else if (wv && wg == g)    stl[g] = 0;
    end
    pick(4, 2, dn, ptr2, ev2, eg2);
    pick(4, 1, dn, ptr1, ev1, eg1);
    pick(3, 1, dn, ptr3, ev3, eg3);
    @(negedge clk);
    chk({tag, " dual"},   {28'(v2), g2}, {28'(ev2), eg2});
    chk({tag, " single"}, {30'(v1), g1}, {30'(ev1[0]), eg1[1:0]});
    chk({tag, " R9 three"}, {30'(v3), g3}, {30'(ev3[0]), eg3[1:0]});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int g = 0; g < NG; g++) begin stl[g] = 0; lat[g] = 0; end
    ptr2 = 3; ptr1 = 3; ptr3 = 2;
    repeat (3) @(negedge clk);
    chk("R1 reset dual",   32'(v2), 32'd0);
    chk("R1 reset single", 32'(v1), 32'd0);
    rst = 1'b0;
    // First clock after reset leaves outputs still invalid only if sampled
    // before the first edge; the first step shows group 0 first.
    step(0, 0, 0, 0, 4'b0000, "R1");        // dual 0,1
    step(0, 0, 0, 0, 4'b0000, "R5");        // dual 2,3
    step(1, 2, 0, 0, 4'b0000, "R2");        // 2 stalled
    step(0, 0, 0, 0, 4'b0000, "R2");
    step(0, 0, 1, 2, 4'b0000, "R3");        // 2 back
    step(1, 1, 1, 1, 4'b0000, "R8");        // stall wins
    step(0, 0, 0, 0, 4'b0000, "R8");
    step(0, 0, 1, 1, 4'b0000, "R3");
    step(0, 0, 0, 0, 4'b1111, "R6");        // nothing runnable
    step(1, 3, 0, 0, 4'b1111, "R6");
    step(1, 0, 0, 0, 4'b0001, "R10");       // stall on done group ignored
    step(0, 0, 0, 0, 4'b0000, "R10");
    step(0, 0, 1, 3, 4'b0000, "R10");       // wake on runnable ignored
    step(1, 0, 0, 0, 4'b0000, "R4");
    step(0, 0, 0, 0, 4'b0001, "R4");        // done clears the stall
    step(0, 0, 0, 0, 4'b0000, "R4");
    step(1, 1, 0, 0, 4'b0000, "R7");
    step(1, 2, 0, 0, 4'b0000, "R7");
    step(1, 3, 0, 0, 4'b0000, "R7");        // only group 0 left
    step(0, 0, 1, 1, 4'b0000, "R7");
    step(0, 0, 1, 2, 4'b0000, "R5");
    step(0, 0, 1, 3, 4'b0000, "R5");

    // Random stall latencies
    for (int cyc = 0; cyc < 4000; cyc++) begin
      bit sv = 0, wv = 0;
      int sg = 0, wg = 0;
      bit [3:0] dn = group_done;
      for (int g = 0; g < NG; g++) if (lat[g] > 0) lat[g]--;
      for (int g = NG - 1; g >= 0; g--)
        if (stl[g] && lat[g] == 0) begin wv = 1; wg = g; end
      if ($urandom_range(99) < 35) begin
        sv = 1;
        sg = (v2[0] && $urandom_range(3) != 0) ? int'(g2[1:0]) : int'($urandom_range(3));
      end
      if ($urandom_range(99) < 3) dn[$urandom_range(3)] ^= 1'b1;
      if (sv && !dn[sg] && !stl[sg]) lat[sg] = int'($urandom_range(15, 1));
      step(sv, sg, wv, wg, dn, "R2 R3 R5 R7");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule